// File: doc/BRIEF.md
# Triangular Spread-Spectrum Offset Generator

This block runs on the reference clock of a fractional-N clock multiplier. Each cycle it produces a signed frequency-offset word that steers the feedback divider. The word sweeps a symmetric triangle around zero, so the synthesized clock spreads evenly above and below its nominal frequency. One of four peak deviations is chosen by a two-bit code. A one-bit select picks a multiplication ratio of one or four.

The peak deviation does not change with the ratio. The modulation period is a fixed count of reference cycles, and that count does depend on the ratio. Each period is split into four equal quarters:

- rise from zero to the positive peak;
- fall back to zero;
- fall to the negative peak;
- rise back to zero.

An error-accumulating stepper builds each ramp with no divider and lands exactly on each end point. A change to the selects is held off until the next period start, so the waveform never jumps.

An enable input is registered and handed on as an output-valid flag for the pad stage. The enable has no effect on the modulation itself.

Top module: `ssc_tri_gen`

## Requirements
- R1: The peak offset magnitude P, in units of 0.01 %, is 0 for spread code 00, 50 for 01, 100 for 10 and 200 for 11. The offset word is signed two's complement.
- R2: Let k be the cycle index from the period start, Q the quarter length, j = k mod Q and m = floor(P·j/Q). The offset is then m in quarter 0, P−m in quarter 1, −m in quarter 2 and m−P in quarter 3.
- R3: Q is 177 cycles when the multiply select is 0 and 155 cycles when it is 1. A period lasts 4·Q cycles, and the offset is zero at k = 2·Q.
- R4: The offset reaches exactly +P at k = Q and exactly −P at k = 3·Q, and never goes outside the range from −P to +P.
- R5: With spread code 00, the offset is zero on every cycle while the phase keeps advancing.
- R6: Spread and multiply selects are sampled only on the clock edge that ends cycle k = 4·Q−1 (and during reset). A change in the middle of a period has no effect until the next period starts.
- R7: The multiplier output is 1 when the active multiply select is 0, and 4 when it is 1.
- R8: The enable flag equals the enable input of the previous cycle, whatever the selects are. The offset word does not depend on the enable input.
- R9: Reset is synchronous and active low. While it is held, the offset is 0, the enable flag is 0, the phase is at the period start, and the selects are loaded on every edge.
- R10: The offset changes by at most 2 units per cycle. It never decreases in quarters 0 and 3, and never increases in quarters 1 and 2.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Synchronous reset, active low |
| spread_sel_i | input | 2 | Peak deviation code |
| mult_sel_i | input | 1 | Multiplication select (0: ×1, 1: ×4) |
| oe_i | input | 1 | Output enable request |
| ofs_o | output | OFS_W (10) | Signed frequency offset in 0.01 % units |
| mult_o | output | MULT_W (3) | Active multiplication factor |
| en_o | output | 1 | Registered output-valid flag |

## Verification
The properties assume every input is synchronous to the reference clock. The selects may change at any time, but they matter only at a period start. The step-size and bound properties also rely on the peak staying below twice the shortest quarter, which the default parameters meet and an elaboration check enforces.

The stimulus drives all inputs on the falling edge, so the design samples settled values. The stimulus sweeps all eight select combinations over full periods. It also switches the selects mid-period, toggles the enable in an irregular pattern, and asserts reset in the middle of a ramp.

// File: rtl/ssc_tri_pkg.sv
package ssc_tri_pkg;

   // Active configuration, sampled only at a period boundary
   typedef struct packed {
      logic [1:0] spread;
      logic       hi_mult;
   } ssc_cfg_t;

   // Quarter segments of one modulation period, in sweep order
   typedef enum logic [1:0] {
      QTR_UP_POS = 2'd0,
      QTR_DN_POS = 2'd1,
      QTR_DN_NEG = 2'd2,
      QTR_UP_NEG = 2'd3
   } qtr_e;

   function automatic int imax(input int a, input int b);
      return (a > b) ? a : b;
   endfunction

   function automatic int imin(input int a, input int b);
      return (a < b) ? a : b;
   endfunction

endpackage

// File: rtl/ssc_cfg_latch.sv
module ssc_cfg_latch
   import ssc_tri_pkg::*;
#(
   parameter int QTR_X1  = 177,
   parameter int QTR_X4  = 155,
   parameter int PEAK_C1 = 50,
   parameter int PEAK_C2 = 100,
   parameter int PEAK_C3 = 200,
   parameter int MULT_LO = 1,
   parameter int MULT_HI = 4,
   parameter int PK_W    = 8,
   parameter int CNT_W   = 8,
   parameter int MULT_W  = 3
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic [1:0]        spread_i,
   input  logic              mult_sel_i,
   output logic [PK_W-1:0]   peak_o,
   output logic [CNT_W-1:0]  qlen_o,
   output logic [MULT_W-1:0] mult_o
);

   ssc_cfg_t cfg_q;

   // Selects load continuously in reset, then only at a period wrap
   always_ff @(posedge clk) begin
      if (!rst_n || load) begin
         cfg_q.spread  <= spread_i;
         cfg_q.hi_mult <= mult_sel_i;
      end
   end

   always_comb begin
      unique case (cfg_q.spread)
         2'd0:    peak_o = '0;
         2'd1:    peak_o = PK_W'(PEAK_C1);
         2'd2:    peak_o = PK_W'(PEAK_C2);
         default: peak_o = PK_W'(PEAK_C3);
      endcase
   end

   assign qlen_o = cfg_q.hi_mult ? CNT_W'(QTR_X4)  : CNT_W'(QTR_X1);
   assign mult_o = cfg_q.hi_mult ? MULT_W'(MULT_HI) : MULT_W'(MULT_LO);

endmodule

// File: rtl/ssc_phase_seq.sv
module ssc_phase_seq
   import ssc_tri_pkg::*;
#(
   parameter int CNT_W = 8
)(
   input  logic             clk,
   input  logic             rst_n,
   input  logic [CNT_W-1:0] qlen_i,
   output logic [CNT_W-1:0] pos_o,
   output qtr_e             qtr_o,
   output logic             qtr_end_o,
   output logic             wrap_o,
   output logic             at_start_o
);

   logic [CNT_W-1:0] pos_q;
   qtr_e             qtr_q;

   assign qtr_end_o  = (pos_q == (qlen_i - CNT_W'(1)));
   assign wrap_o     = qtr_end_o && (qtr_q == QTR_UP_NEG);
   assign at_start_o = (pos_q == '0) && (qtr_q == QTR_UP_POS);
   assign pos_o      = pos_q;
   assign qtr_o      = qtr_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pos_q <= '0;
         qtr_q <= QTR_UP_POS;
      end else if (qtr_end_o) begin
         pos_q <= '0;
         qtr_q <= qtr_e'(qtr_q + 2'd1);
      end else begin
         pos_q <= pos_q + CNT_W'(1);
      end
   end

endmodule

// File: rtl/ssc_ramp_stepper.sv
module ssc_ramp_stepper #(
   parameter int PK_W     = 8,
   parameter int CNT_W    = 8,
   parameter int PEAK_MAX = 200,
   parameter int QTR_MIN  = 155
)(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             restart_i,
   input  logic [PK_W-1:0]  peak_i,
   input  logic [CNT_W-1:0] qlen_i,
   output logic [PK_W-1:0]  mag_o
);

   localparam int SUM_W = ((PK_W > CNT_W) ? PK_W : CNT_W) + 2;

   logic [SUM_W-1:0] err_q;
   logic [SUM_W-1:0] sum;
   logic [SUM_W-1:0] q_ext;
   logic [SUM_W-1:0] rem;
   logic [1:0]       step;

   assign q_ext = SUM_W'(qlen_i);
   assign sum   = err_q + SUM_W'(peak_i);

   // A peak below the quarter length never needs more than one unit per cycle
   generate
      if (PEAK_MAX >= 2 * QTR_MIN) begin : g_bad_ratio
         $error("ssc_ramp_stepper: peak must stay below twice the quarter length");
      end

      if (PEAK_MAX < QTR_MIN) begin : g_one_step
         always_comb begin
            if (sum >= q_ext) begin
               step = 2'd1;
               rem  = sum - q_ext;
            end else begin
               step = 2'd0;
               rem  = sum;
            end
         end
      end else begin : g_two_step
         always_comb begin
            if (sum >= (q_ext << 1)) begin
               step = 2'd2;
               rem  = sum - (q_ext << 1);
            end else if (sum >= q_ext) begin
               step = 2'd1;
               rem  = sum - q_ext;
            end else begin
               step = 2'd0;
               rem  = sum;
            end
         end
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n || restart_i) begin
         mag_o <= '0;
         err_q <= '0;
      end else begin
         mag_o <= mag_o + PK_W'(step);
         err_q <= rem;
      end
   end

endmodule

// File: rtl/ssc_tri_shape.sv
module ssc_tri_shape
   import ssc_tri_pkg::*;
#(
   parameter int PK_W  = 8,
   parameter int OFS_W = 10
)(
   input  qtr_e                     qtr_i,
   input  logic [PK_W-1:0]          mag_i,
   input  logic [PK_W-1:0]          peak_i,
   output logic signed [OFS_W-1:0]  ofs_o
);

   logic signed [OFS_W-1:0] m_s;
   logic signed [OFS_W-1:0] p_s;

   always_comb begin
      m_s = '0;
      p_s = '0;
      m_s[PK_W-1:0] = mag_i;
      p_s[PK_W-1:0] = peak_i;
      unique case (qtr_i)
         QTR_UP_POS: ofs_o = m_s;
         QTR_DN_POS: ofs_o = p_s - m_s;
         QTR_DN_NEG: ofs_o = -m_s;
         QTR_UP_NEG: ofs_o = m_s - p_s;
         default:    ofs_o = '0;
      endcase
   end

endmodule

// File: rtl/ssc_tri_gen.sv
module ssc_tri_gen
   import ssc_tri_pkg::*;
#(
   parameter int OFS_W   = 10,
   parameter int QTR_X1  = 177,
   parameter int QTR_X4  = 155,
   parameter int PEAK_C1 = 50,
   parameter int PEAK_C2 = 100,
   parameter int PEAK_C3 = 200,
   parameter int MULT_LO = 1,
   parameter int MULT_HI = 4,
   parameter int MULT_W  = 3
)(
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic [1:0]              spread_sel_i,
   input  logic                    mult_sel_i,
   input  logic                    oe_i,
   output logic signed [OFS_W-1:0] ofs_o,
   output logic [MULT_W-1:0]       mult_o,
   output logic                    en_o
);

   localparam int PEAK_MAX = imax(PEAK_C1, imax(PEAK_C2, PEAK_C3));
   localparam int QTR_MAX  = imax(QTR_X1, QTR_X4);
   localparam int QTR_MIN  = imin(QTR_X1, QTR_X4);
   localparam int PK_W     = $clog2(PEAK_MAX + 1);
   localparam int CNT_W    = $clog2(QTR_MAX + 1);

   generate
      if (QTR_MIN < 2) begin : g_bad_qtr
         $error("ssc_tri_gen: quarter length must be at least 2");
      end
      if (PK_W >= OFS_W) begin : g_bad_ofs
         $error("ssc_tri_gen: offset word too narrow for the peak");
      end
      if (imax(MULT_LO, MULT_HI) >= (1 << MULT_W)) begin : g_bad_mult
         $error("ssc_tri_gen: multiplier width too small");
      end
   endgenerate

   logic [PK_W-1:0]  act_peak;
   logic [CNT_W-1:0] act_qlen;
   logic [CNT_W-1:0] pos;
   qtr_e             qtr;
   logic             qtr_end;
   logic             prd_wrap;
   logic             at_start;
   logic [PK_W-1:0]  mag;

   ssc_cfg_latch #(
      .QTR_X1 (QTR_X1), .QTR_X4 (QTR_X4),
      .PEAK_C1(PEAK_C1), .PEAK_C2(PEAK_C2), .PEAK_C3(PEAK_C3),
      .MULT_LO(MULT_LO), .MULT_HI(MULT_HI),
      .PK_W   (PK_W),    .CNT_W  (CNT_W),   .MULT_W (MULT_W)
   ) u_cfg (
      .clk       (clk),
      .rst_n     (rst_n),
      .load      (prd_wrap),
      .spread_i  (spread_sel_i),
      .mult_sel_i(mult_sel_i),
      .peak_o    (act_peak),
      .qlen_o    (act_qlen),
      .mult_o    (mult_o)
   );

   ssc_phase_seq #(.CNT_W(CNT_W)) u_seq (
      .clk       (clk),
      .rst_n     (rst_n),
      .qlen_i    (act_qlen),
      .pos_o     (pos),
      .qtr_o     (qtr),
      .qtr_end_o (qtr_end),
      .wrap_o    (prd_wrap),
      .at_start_o(at_start)
   );

   ssc_ramp_stepper #(
      .PK_W(PK_W), .CNT_W(CNT_W), .PEAK_MAX(PEAK_MAX), .QTR_MIN(QTR_MIN)
   ) u_step (
      .clk      (clk),
      .rst_n    (rst_n),
      .restart_i(qtr_end),
      .peak_i   (act_peak),
      .qlen_i   (act_qlen),
      .mag_o    (mag)
   );

   ssc_tri_shape #(.PK_W(PK_W), .OFS_W(OFS_W)) u_shape (
      .qtr_i (qtr),
      .mag_i (mag),
      .peak_i(act_peak),
      .ofs_o (ofs_o)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) en_o <= 1'b0;
      else        en_o <= oe_i;
   end

endmodule

// File: rtl/ssc_tri_chk.sv
module ssc_tri_chk #(
   parameter int OFS_W  = 10,
   parameter int PK_W   = 8,
   parameter int MULT_W = 3
)(
   input logic                    clk,
   input logic                    rst_n,
   input logic                    oe_i,
   input logic signed [OFS_W-1:0] ofs_o,
   input logic [MULT_W-1:0]       mult_o,
   input logic                    en_o,
   input logic [PK_W-1:0]         peak,
   input logic                    prd_wrap,
   input logic                    at_start
);

   AST_STEP_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
      $past(rst_n) |-> (((ofs_o - $past(ofs_o)) <= 2) && ((ofs_o - $past(ofs_o)) >= -2))); // R10

   AST_EN_FOLLOW: assert property (@(posedge clk) disable iff (!rst_n)
      $past(rst_n) |-> (en_o == $past(oe_i))); // R8

   AST_CFG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && !$past(prd_wrap)) |-> ($stable(mult_o) && $stable(peak))); // R6

   AST_PEAK_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      (ofs_o <= $signed({1'b0, peak})) && (ofs_o >= -$signed({1'b0, peak}))); // R4

   AST_START_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      at_start |-> (ofs_o == '0)); // R2

   AST_FLAT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (peak == '0) |-> (ofs_o == '0)); // R5

endmodule

bind ssc_tri_gen ssc_tri_chk #(.OFS_W(OFS_W), .PK_W(PK_W), .MULT_W(MULT_W)) u_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .oe_i    (oe_i),
   .ofs_o   (ofs_o),
   .mult_o  (mult_o),
   .en_o    (en_o),
   .peak    (act_peak),
   .prd_wrap(prd_wrap),
   .at_start(at_start)
);

// File: tb/ssc_tri_gen_test.sv
module ssc_tri_gen_test;

   localparam int CLK_PERIOD = 10;
   localparam int OFS_W      = 10;

   logic                    clk = 1'b0;
   logic                    rst_n = 1'b0;
   logic [1:0]              spread = 2'd0;
   logic                    msel = 1'b0;
   logic                    oe = 1'b0;
   logic signed [OFS_W-1:0] ofs;
   logic [2:0]              mult;
   logic                    en;

   int n_chk = 0;
   int n_err = 0;

   // Reference model state
   int  k = 0;
   int  m_sp = 0;
   int  m_hi = 0;
   int  e_en = 0;
   bit  have_edge = 0;
   bit  pv = 0;
   int  prev_ofs = 0;

   ssc_tri_gen uut (
      .clk         (clk),
      .rst_n       (rst_n),
      .spread_sel_i(spread),
      .mult_sel_i  (msel),
      .oe_i        (oe),
      .ofs_o       (ofs),
      .mult_o      (mult),
      .en_o        (en)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   function automatic int peak_of(input int s);
      case (s)
         0: return 0;
         1: return 50;
         2: return 100;
         default: return 200;
      endcase
   endfunction

   function automatic int qlen_of(input int h);
      return h ? 155 : 177;
   endfunction

   function automatic int exp_ofs(input int p, input int q, input int kk);
      int qq = kk / q;
      int j  = kk % q;
      int m  = (p * j) / q;
      case (qq)
         0: return m;
         1: return p - m;
         2: return -m;
         default: return m - p;
      endcase
   endfunction

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_err++;
         $display("FAIL %s: actual %0d expected %0d (k=%0d)", req, act, exp, k);
      end
   endtask

   // One clock: update the model at the rising edge, compare at the falling edge
   task automatic tick();
      int p, q, e, o, d, qq;
      @(posedge clk);
      if (!rst_n) begin
         k = 0; m_sp = int'(spread); m_hi = int'(msel); e_en = 0; pv = 0;
      end else begin
         if (k == 4 * qlen_of(m_hi) - 1) begin
            k = 0; m_sp = int'(spread); m_hi = int'(msel);
         end else begin
            k++;
         end
         e_en = int'(oe);
      end
      have_edge = 1;
      @(negedge clk);
      p = peak_of(m_sp);
      q = qlen_of(m_hi);
      e = exp_ofs(p, q, k);
      o = int'(ofs);
      chk(o == e, "R2", o, e);
      if (k == q)     chk(o == p,  "R1", o, p);
      if (k == 2 * q) chk(o == 0,  "R3", o, 0);
      if (k == 3 * q) chk(o == -p, "R4", o, -p);
      if (m_sp == 0)  chk(o == 0,  "R5", o, 0);
      chk(int'(mult) == (m_hi ? 4 : 1), "R7", int'(mult), m_hi ? 4 : 1);
      if (!rst_n) begin
         chk(o == 0, "R9", o, 0);
         chk(en == 1'b0, "R9", int'(en), 0);
      end else begin
         chk(int'(en) == e_en, "R8", int'(en), e_en);
      end
      if (pv && rst_n && k > 0) begin
         d  = o - prev_ofs;
         qq = (k - 1) / q;
         chk(d <= 2 && d >= -2, "R10", d, 2);
         if (qq == 0 || qq == 3) chk(d >= 0, "R10", d, 0);
         else                    chk(d <= 0, "R10", d, 0);
      end
      prev_ofs = o;
      pv = rst_n;
   endtask

   task automatic do_reset(input int n);
      rst_n = 1'b0;
      repeat (n) tick();
      rst_n = 1'b1;
   endtask

   initial begin
      #(CLK_PERIOD * 200000);
      n_chk++;
      n_err++;
      $display("FAIL R9: watchdog expired, actual running expected finished");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
   end

   initial begin
      @(negedge clk);
      // R1 R3 R4 R5 R7: every select combination over one full period
      for (int c = 0; c < 8; c++) begin
         spread = c[1:0];
         msel   = c[2];
         oe     = 1'b1;
         do_reset(3);
         repeat (4 * qlen_of(c / 4) + 12) tick();
      end

      // R6: change the selects mid-period, then wait for the boundary
      spread = 2'd3; msel = 1'b0;
      do_reset(2);
      repeat (300) tick();
      spread = 2'd1; msel = 1'b1;
      tick();
      chk(int'(mult) == 1, "R6", int'(mult), 1);
      while (k != 0) tick();
      chk(int'(mult) == 4, "R6", int'(mult), 4);
      repeat (20) tick();
      chk(int'(ofs) == exp_ofs(50, 155, k), "R6", int'(ofs), exp_ofs(50, 155, k));

      // R8: irregular enable pattern; offset must still follow the model
      spread = 2'd2; msel = 1'b0;
      for (int i = 0; i < 1300; i++) begin
         oe = ((i % 7) < 3) || ((i % 11) == 5);
         tick();
      end

      // R9: reset in the middle of a ramp
      oe = 1'b1;
      do_reset(3);
      repeat (200) tick();

      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
   end

endmodule